// File: doc/BRIEF.md
# Serial Polynomial Signature Divider

This block compacts a serial response stream from a circuit under test into a short signature. It works as a polynomial divider built from a modular LFSR, with the XOR gates placed between the stages. The response bits form the coefficients of a polynomial, and the bit shifted in first carries the highest power. On every enabled clock one bit enters stage 0. The top stage feeds back through the taps of a characteristic polynomial, and the same top-stage bit leaves on the quotient output.

A test controller first issues a clear, which sets the register to an all-zero seed. It then streams the response in and finally pulses a done strobe. At that strobe the parallel signature, which is the division remainder, is compared with a supplied golden value. The registered pass flag reports an exact match on the next cycle. The characteristic polynomial and its degree are parameters. By default the polynomial is 1 + x + x^3 + x^5.

Top module: `sig_analyzer`

## Requirements
- R1: The active-low asynchronous reset, and a synchronous clear on `clr_i`, force `sig_o` to zero and `pass_o` to 0. A clear overrides an enable and a done strobe in the same cycle.
- R2: In a cycle with `en_i` high and no clear, let q be the old `sig_o[DEG-1]`. The new stage 0 becomes `data_i ^ (q & POLY[0])` and each stage i>0 becomes old stage i-1 ^ (q & POLY[i]). `POLY` bit i is the coefficient of x^i, and the x^DEG term is implied.
- R3: With `en_i` low and no clear, `sig_o` keeps its value whatever `data_i` does.
- R4: `quot_o` shows the bit that the next shift will emit. Over a stream that starts from a clear, these bits are the quotient coefficients, highest power first: the first DEG emitted bits are 0, and later ones follow the long division.
- R5: After N shifts from a clear, `sig_o` holds the remainder of the N-bit input polynomial divided by the characteristic polynomial, with bit i being the coefficient of x^i. With the default polynomial, the stream 1,0,0,0,1,0,1,0 (x^7 + x^3 + x) leaves `sig_o` = 5'b01101 (1 + x^2 + x^3) and emits quotient bits 0,0,0,0,0,1,0,1 (x^2 + 1).
- R6: A done strobe without a clear sets `pass_o` on the next cycle to 1 only when `sig_o` equals `golden_i` exactly. A difference in any single bit gives 0.
- R7: `pass_o` holds its value between done strobes. When `done_i` and `en_i` are high in the same cycle, the comparison uses the signature from before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear to the zero seed |
| en_i | input | 1 | Shift one response bit in |
| data_i | input | 1 | Serial response bit, highest power first |
| done_i | input | 1 | End-of-stream strobe that triggers the comparison |
| golden_i | input | DEG | Good-machine signature |
| quot_o | output | 1 | Quotient bit emitted by the current shift |
| sig_o | output | DEG | Running remainder (signature) |
| pass_o | output | 1 | Registered exact-match flag |

## Verification
The worked division x^7 + x^3 + x is run bit by bit. It separates a correct tap placement from a shifted or mirrored one, because both the remainder 1 + x^2 + x^3 and the quotient x^2 + 1 must come out. Random streams of varying length, with idle gaps between bits, are checked at every shift against a long-division model. This exposes errors in the feedback that only appear once the top stage holds a 1, and it separates holding from shifting. Golden values that match exactly, or that differ in one random bit, separate an exact compare from a partial one. A done strobe that coincides with a shift, and a clear that coincides with both, pin down the ordering rules.

// File: rtl/sig_analyzer_pkg.sv
package sig_analyzer_pkg;
  localparam int unsigned DEF_DEG = 5;
  localparam logic [DEF_DEG-1:0] DEF_POLY = 5'b01011;  // 1 + x + x^3 (+ x^5)

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_CLEAR = 2'd2
  } op_e;
endpackage

// File: rtl/sig_analyzer_ctrl.sv
module sig_analyzer_ctrl
  import sig_analyzer_pkg::*;
(
  input  logic clr_i,
  input  logic en_i,
  input  logic done_i,
  output op_e  op_o,
  output logic cmp_o
);
  always_comb begin
    if (clr_i)     op_o = OP_CLEAR;
    else if (en_i) op_o = OP_SHIFT;
    else           op_o = OP_HOLD;
  end

  assign cmp_o = done_i & ~clr_i;
endmodule

// File: rtl/sig_analyzer_div.sv
module sig_analyzer_div
  import sig_analyzer_pkg::*;
#(
  parameter int unsigned       DEG  = DEF_DEG,
  parameter logic [DEG-1:0]    POLY = DEF_POLY
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  op_e            op_i,
  input  logic           data_i,
  output logic           quot_o,
  output logic [DEG-1:0] rem_o
);
  logic [DEG-1:0] rem_q, rem_d, shifted;
  logic           fb;

  assign fb = rem_q[DEG-1];

  // modular divider: tap XOR sits in front of each stage
  generate
    for (genvar i = 0; i < DEG; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign shifted[i] = data_i ^ (fb & POLY[i]);
      end else begin : g_body
        assign shifted[i] = rem_q[i-1] ^ (fb & POLY[i]);
      end
    end
  endgenerate

  always_comb begin
    unique case (op_i)
      OP_CLEAR: rem_d = '0;
      OP_SHIFT: rem_d = shifted;
      default:  rem_d = rem_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rem_q <= '0;
    else         rem_q <= rem_d;
  end

  assign quot_o = fb;
  assign rem_o  = rem_q;
endmodule

// File: rtl/sig_analyzer_cmp.sv
module sig_analyzer_cmp
  import sig_analyzer_pkg::*;
#(
  parameter int unsigned DEG = DEF_DEG
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  op_e            op_i,
  input  logic           cmp_i,
  input  logic [DEG-1:0] sig_i,
  input  logic [DEG-1:0] golden_i,
  output logic           pass_o
);
  logic pass_q;
  logic [DEG-1:0] diff;

  assign diff = sig_i ^ golden_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pass_q <= 1'b0;
    else if (op_i == OP_CLEAR) pass_q <= 1'b0;
    else if (cmp_i)            pass_q <= ~|diff;
  end

  assign pass_o = pass_q;
endmodule

// File: rtl/sig_analyzer.sv
module sig_analyzer
  import sig_analyzer_pkg::*;
#(
  parameter int unsigned    DEG  = DEF_DEG,
  parameter logic [DEG-1:0] POLY = DEF_POLY
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           en_i,
  input  logic           data_i,
  input  logic           done_i,
  input  logic [DEG-1:0] golden_i,
  output logic           quot_o,
  output logic [DEG-1:0] sig_o,
  output logic           pass_o
);
  op_e  op;
  logic cmp;

  sig_analyzer_ctrl u_ctrl (
    .clr_i  (clr_i),
    .en_i   (en_i),
    .done_i (done_i),
    .op_o   (op),
    .cmp_o  (cmp)
  );

  sig_analyzer_div #(.DEG(DEG), .POLY(POLY)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .data_i (data_i),
    .quot_o (quot_o),
    .rem_o  (sig_o)
  );

  sig_analyzer_cmp #(.DEG(DEG)) u_cmp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .cmp_i    (cmp),
    .sig_i    (sig_o),
    .golden_i (golden_i),
    .pass_o   (pass_o)
  );
endmodule

// File: rtl/sig_analyzer_chk.sv
module sig_analyzer_chk #(
  parameter int unsigned    DEG  = 5,
  parameter logic [DEG-1:0] POLY = 5'b01011
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           clr_i,
  input logic           en_i,
  input logic           data_i,
  input logic           done_i,
  input logic [DEG-1:0] golden_i,
  input logic           quot_o,
  input logic [DEG-1:0] sig_o,
  input logic           pass_o
);
  AST_CLR_SIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sig_o == '0)); // R1
  AST_CLR_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !pass_o); // R1
  AST_SHIFT_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |=> (sig_o[0] == ($past(data_i) ^ ($past(quot_o) & POLY[0])))); // R2
  AST_SHIFT_BODY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |=> (sig_o[DEG-1:1] ==
      ($past(sig_o[DEG-2:0]) ^ ({(DEG-1){$past(quot_o)}} & POLY[DEG-1:1])))); // R2
  AST_HOLD_SIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(sig_o)); // R3
  AST_PASS_EVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !clr_i) |=> (pass_o == ($past(sig_o) == $past(golden_i)))); // R6
  AST_PASS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_i && !clr_i) |=> $stable(pass_o)); // R7
endmodule

bind sig_analyzer sig_analyzer_chk #(.DEG(DEG), .POLY(POLY)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clr_i    (clr_i),
  .en_i     (en_i),
  .data_i   (data_i),
  .done_i   (done_i),
  .golden_i (golden_i),
  .quot_o   (quot_o),
  .sig_o    (sig_o),
  .pass_o   (pass_o)
);

// File: tb/sig_analyzer_bench.sv
`timescale 1ns/1ps
module sig_analyzer_bench;
  localparam int unsigned    DEG  = 5;
  localparam logic [DEG-1:0] POLY = 5'b01011;
  localparam logic [63:0]    GFULL = (64'd1 << DEG) | 64'(POLY);

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           clr_i = 1'b0, en_i = 1'b0, data_i = 1'b0, done_i = 1'b0;
  logic [DEG-1:0] golden_i = '0;
  logic           quot_o, pass_o;
  logic [DEG-1:0] sig_o;

  int nchk = 0, nerr = 0;
  logic [63:0] mp;
  int mn;

  always #2.5 clk_i = ~clk_i;

  sig_analyzer #(.DEG(DEG), .POLY(POLY)) u_sig_analyzer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .en_i(en_i), .data_i(data_i),
    .done_i(done_i), .golden_i(golden_i), .quot_o(quot_o), .sig_o(sig_o), .pass_o(pass_o)
  );

  // long division of an n-bit polynomial (bit i = coeff of x^i)
  function automatic logic [DEG-1:0] rem_of(input logic [63:0] p, input int n);
    logic [63:0] r;
    r = p;
    for (int i = n - 1; i >= int'(DEG); i--)
      if (r[i]) r = r ^ (GFULL << (i - DEG));
    return r[DEG-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_clear();
    clr_i = 1'b1;
    tick();
    clr_i = 1'b0;
    mp = '0;
    mn = 0;
    chk(sig_o == '0, "R1 clear sig", 32'(sig_o), 0);
    chk(pass_o == 1'b0, "R1 clear pass", 32'(pass_o), 0);
  endtask

  task automatic shift_bit(input logic d, input bit check_q, input logic exp_q_in);
    logic [DEG-1:0] r;
    r = rem_of(mp, mn);
    en_i = 1'b1;
    data_i = d;
    #0.1;
    chk(quot_o == r[DEG-1], "R4 quotient bit", 32'(quot_o), 32'(r[DEG-1]));
    if (check_q) chk(quot_o == exp_q_in, "R5 example quotient", 32'(quot_o), 32'(exp_q_in));
    tick();
    en_i = 1'b0;
    mp = {mp[62:0], d};
    mn++;
    r = rem_of(mp, mn);
    chk(sig_o == r, "R2 R5 remainder after shift", 32'(sig_o), 32'(r));
  endtask

  task automatic do_done(input logic [DEG-1:0] g, input bit exp_pass);
    done_i = 1'b1;
    golden_i = g;
    tick();
    done_i = 1'b0;
    chk(pass_o == exp_pass, "R6 pass flag", 32'(pass_o), 32'(exp_pass));
  endtask

  initial begin
    logic [7:0] ex_bits;
    logic [7:0] ex_quot;
    logic [DEG-1:0] hold_sig, g, pre;
    bit hold_pass;
    void'($urandom(32'd587));

    // reset state
    repeat (3) @(posedge clk_i);
    #1;
    chk(sig_o == '0, "R1 reset sig", 32'(sig_o), 0);
    chk(pass_o == 1'b0, "R1 reset pass", 32'(pass_o), 0);
    rst_ni = 1'b1;
    tick();

    // worked example: x^7 + x^3 + x, highest power first
    do_clear();
    ex_bits = 8'b1000_1010;
    ex_quot = 8'b0000_0101;
    for (int k = 7; k >= 0; k--) shift_bit(ex_bits[k], 1'b1, ex_quot[k]);
    chk(sig_o == 5'b01101, "R5 example remainder", 32'(sig_o), 32'h0d);
    do_done(5'b01101, 1'b1);
    do_done(5'b01100, 1'b0);
    do_done(5'b01101, 1'b1);

    // hold with enable low and toggling data
    hold_sig = sig_o;
    hold_pass = pass_o;
    for (int k = 0; k < 6; k++) begin
      data_i = 1'($urandom);
      golden_i = DEG'($urandom);
      tick();
      chk(sig_o == hold_sig, "R3 hold sig", 32'(sig_o), 32'(hold_sig));
      chk(pass_o == hold_pass, "R7 pass holds", 32'(pass_o), 32'(hold_pass));
    end

    // random streams with idle gaps
    for (int s = 0; s < 30; s++) begin
      int len;
      do_clear();
      len = 6 + int'($urandom % 35);
      for (int k = 0; k < len; k++) begin
        shift_bit(1'($urandom), 1'b0, 1'b0);
        if (($urandom % 4) == 0) begin
          hold_sig = sig_o;
          data_i = 1'($urandom);
          tick();
          chk(sig_o == hold_sig, "R3 idle gap", 32'(sig_o), 32'(hold_sig));
        end
      end
      if (s % 2 == 0) g = sig_o;
      else g = sig_o ^ DEG'(1 << ($urandom % DEG));
      do_done(g, s % 2 == 0);
    end

    // done together with a shift compares the pre-shift signature
    do_clear();
    for (int k = 0; k < 9; k++) shift_bit(1'($urandom), 1'b0, 1'b0);
    pre = sig_o;
    done_i = 1'b1;
    en_i = 1'b1;
    data_i = 1'b1;
    golden_i = pre;
    tick();
    done_i = 1'b0;
    en_i = 1'b0;
    chk(pass_o == 1'b1, "R7 done with shift uses old sig", 32'(pass_o), 1);
    mp = {mp[62:0], 1'b1};
    mn++;
    chk(sig_o == rem_of(mp, mn), "R2 shift during done", 32'(sig_o), 32'(rem_of(mp, mn)));

    // clear beats enable and done
    clr_i = 1'b1;
    en_i = 1'b1;
    done_i = 1'b1;
    data_i = 1'b1;
    golden_i = '0;
    tick();
    clr_i = 1'b0;
    en_i = 1'b0;
    done_i = 1'b0;
    chk(sig_o == '0, "R1 clear over shift", 32'(sig_o), 0);
    chk(pass_o == 1'b0, "R1 clear over done", 32'(pass_o), 0);

    // asynchronous reset mid-stream
    mp = '0;
    mn = 0;
    for (int k = 0; k < 7; k++) shift_bit(1'($urandom), 1'b0, 1'b0);
    do_done(sig_o, 1'b1);
    #1.2;
    rst_ni = 1'b0;
    #0.5;
    chk(sig_o == '0, "R1 async reset sig", 32'(sig_o), 0);
    chk(pass_o == 1'b0, "R1 async reset pass", 32'(pass_o), 0);
    tick();
    rst_ni = 1'b1;
    tick();

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule